// File: doc/BRIEF.md
# OLED Panel Bring-Up Sequencer

This block configures a small OLED panel controller from power-up without any processor involvement. On a start strobe it first pulses the panel's reset line. It then streams a fixed register script to the controller over a transmit-only SPI link. The link uses a separate data/command select line, so the panel can tell register indices from register values.

The script is a list of index/value writes. Two millisecond-scale pauses let the panel's oscillator and current reference settle. The last step is a lone index byte that leaves the panel ready to accept pixel data. Once that byte is out, a pixel streamer elsewhere in the chip can take over the link.

The system clock frequency and pause length are parameters, so the pause is exact in cycles for any clock. The SPI clock rate and the reset pulse width are also parameters.

Top module: `oled_boot_seq`

## Requirements
- R1: While reset is asserted, and in idle after reset, busy and done are low, chip select (active low) is high, the SPI clock is low, and the panel reset output is low. No frame is sent until start is pulsed.
- R2: After start, the panel reset output goes high for RST_CYC cycles and then low for RST_CYC cycles. Chip select stays high throughout this pulse.
- R3: Every byte is its own chip-select frame of exactly 8 SPI clock rising edges. The link uses mode 0 (clock idles low, data sampled on the rising edge) and sends the most significant bit first. Each SPI clock half period lasts SCK_HALF system cycles.
- R4: The DC line is 0 for a register-index byte and 1 for a register-value byte, and it is stable for the whole frame.
- R5: The script writes (index then value, hex) start with 04:03 and 04:00. They continue with 3B:00, 02:01, 03:90, 80:01, 08:04, 09:05, 0A:05, 0B:9D, 0C:8C, 0D:57.
- R6: The script continues with 10:56, 11:4D, 12:46, 13:00, 14:01, 16:66, 28:7F, 29:00, 06:01, 05:00, 15:00. Every write is one index frame followed by one value frame.
- R7: A pause of CLK_HZ/1000*WAIT_MS cycles follows the value frame of each of the first two writes. No other frame boundary has a pause.
- R8: The script ends with the single index byte 22 (DC=0) and no value frame, giving 47 frames in total.
- R9: Busy rises the cycle after start and stays high until the final frame's chip select has been released. Done is a one-cycle pulse in the cycle busy falls.
- R10: A start pulse while busy is ignored: the run still sends exactly 47 frames and produces one done pulse.
- R11: After done, a new start replays the whole sequence, including the reset pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run the bring-up sequence |
| spi_sck | output | 1 | SPI clock, mode 0 |
| spi_mosi | output | 1 | SPI serial data, MSB first |
| spi_cs_n | output | 1 | Active-low chip select, one frame per byte |
| panel_dc | output | 1 | 0 = register index byte, 1 = register value byte |
| panel_rst | output | 1 | Panel reset pulse output |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at sequence end |

## Verification
Some properties are checked on every cycle by the assertions:
- the SPI clock toggles only inside a frame;
- MOSI and DC hold steady while the clock is high or the frame is open;
- no frame overlaps the reset pulse;
- done lasts one cycle and coincides with busy falling;
- the script pointer stays in range.

The byte contents, their order and DC levels, the bit count per frame, and the length of the two pauses depend on the script. So do the number of frames per run, the rejection of a start during a run, and replay after done. Only the bench's scenarios, which decode the SPI traffic at the pins, can show these.

// File: rtl/oled_boot_pkg.sv
package oled_boot_pkg;

    localparam int STEPS  = 24;
    localparam int PTR_W  = $clog2(STEPS);

    typedef struct packed {
        logic [7:0] idx;
        logic [7:0] val;
        logic       has_val;
        logic       pause;
    } step_t;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_RST_HI, SQ_RST_LO, SQ_IDX, SQ_VAL, SQ_PAUSE
    } seq_e;

    typedef enum logic [1:0] {
        TX_IDLE, TX_SHIFT, TX_GAP
    } tx_e;

endpackage

// File: rtl/oled_boot_rom.sv
module oled_boot_rom
    import oled_boot_pkg::*;
(
    input  logic [PTR_W-1:0] addr,
    output step_t            step
);
    // Script order is behaviour: each entry is one write, pause marks the settle waits.
    always_comb begin
        case (addr)
            5'd0:    step = '{8'h04, 8'h03, 1'b1, 1'b1};
            5'd1:    step = '{8'h04, 8'h00, 1'b1, 1'b1};
            5'd2:    step = '{8'h3B, 8'h00, 1'b1, 1'b0};
            5'd3:    step = '{8'h02, 8'h01, 1'b1, 1'b0};
            5'd4:    step = '{8'h03, 8'h90, 1'b1, 1'b0};
            5'd5:    step = '{8'h80, 8'h01, 1'b1, 1'b0};
            5'd6:    step = '{8'h08, 8'h04, 1'b1, 1'b0};
            5'd7:    step = '{8'h09, 8'h05, 1'b1, 1'b0};
            5'd8:    step = '{8'h0A, 8'h05, 1'b1, 1'b0};
            5'd9:    step = '{8'h0B, 8'h9D, 1'b1, 1'b0};
            5'd10:   step = '{8'h0C, 8'h8C, 1'b1, 1'b0};
            5'd11:   step = '{8'h0D, 8'h57, 1'b1, 1'b0};
            5'd12:   step = '{8'h10, 8'h56, 1'b1, 1'b0};
            5'd13:   step = '{8'h11, 8'h4D, 1'b1, 1'b0};
            5'd14:   step = '{8'h12, 8'h46, 1'b1, 1'b0};
            5'd15:   step = '{8'h13, 8'h00, 1'b1, 1'b0};
            5'd16:   step = '{8'h14, 8'h01, 1'b1, 1'b0};
            5'd17:   step = '{8'h16, 8'h66, 1'b1, 1'b0};
            5'd18:   step = '{8'h28, 8'h7F, 1'b1, 1'b0};
            5'd19:   step = '{8'h29, 8'h00, 1'b1, 1'b0};
            5'd20:   step = '{8'h06, 8'h01, 1'b1, 1'b0};
            5'd21:   step = '{8'h05, 8'h00, 1'b1, 1'b0};
            5'd22:   step = '{8'h15, 8'h00, 1'b1, 1'b0};
            default: step = '{8'h22, 8'h00, 1'b0, 1'b0};
        endcase
    end
endmodule

// File: rtl/oled_spi_tx.sv
module oled_spi_tx
    import oled_boot_pkg::*;
#(
    parameter int SCK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] byte_in,
    input  logic       dc_in,
    output logic       sck,
    output logic       mosi,
    output logic       cs_n,
    output logic       dc,
    output logic       idle
);
    localparam int CW = $clog2(SCK_HALF) + 1;

    typedef struct packed {
        tx_e          st;
        logic [7:0]   sh;
        logic [2:0]   bits;
        logic [CW-1:0] cnt;
        logic         sck;
        logic         cs_n;
        logic         dc;
    } tx_t;

    tx_t q, d;
    logic half_end;

    assign half_end = (q.cnt == CW'(SCK_HALF - 1));

    always_comb begin
        d = q;
        case (q.st)
            TX_IDLE: begin
                if (go) begin
                    d.st   = TX_SHIFT;
                    d.sh   = byte_in;
                    d.bits = '0;
                    d.cnt  = '0;
                    d.sck  = 1'b0;
                    d.cs_n = 1'b0;
                    d.dc   = dc_in;
                end
            end
            TX_SHIFT: begin
                if (half_end) begin
                    d.cnt = '0;
                    if (!q.sck) begin
                        d.sck = 1'b1;
                    end else begin
                        d.sck = 1'b0;
                        if (q.bits == 3'd7) begin
                            d.cs_n = 1'b1;
                            d.st   = TX_GAP;
                        end else begin
                            d.bits = q.bits + 3'd1;
                            d.sh   = {q.sh[6:0], 1'b0};
                        end
                    end
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            TX_GAP: begin
                if (half_end) begin
                    d.cnt = '0;
                    d.st  = TX_IDLE;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            default: d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: TX_IDLE, sh: '0, bits: '0, cnt: '0, sck: 1'b0, cs_n: 1'b1, dc: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sck  = q.sck;
    assign mosi = q.sh[7];
    assign cs_n = q.cs_n;
    assign dc   = q.dc;
    assign idle = (q.st == TX_IDLE);

    // R3
    sck_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.sck |-> !q.cs_n);
    // R3
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sck && $past(q.sck)) |-> $stable(mosi));
    // R4
    dc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.cs_n && $past(!q.cs_n)) |-> $stable(q.dc));
endmodule

// File: rtl/oled_boot_seq.sv
module oled_boot_seq
    import oled_boot_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int WAIT_MS  = 5,
    parameter int SCK_HALF = 4,
    parameter int RST_CYC  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic spi_sck,
    output logic spi_mosi,
    output logic spi_cs_n,
    output logic panel_dc,
    output logic panel_rst,
    output logic busy,
    output logic done
);
    localparam int WAIT_CYC = (CLK_HZ / 1000) * WAIT_MS;
    localparam int CNT_MAX  = (WAIT_CYC > RST_CYC) ? WAIT_CYC : RST_CYC;
    localparam int CW       = $clog2(CNT_MAX + 1);

    typedef struct packed {
        seq_e             st;
        logic [PTR_W-1:0] ptr;
        logic [CW-1:0]    cnt;
        logic             sent;
        logic             go;
        logic             prst;
        logic             done;
    } seq_t;

    seq_t  q, d;
    step_t step;
    logic  tx_idle;
    logic  byte_done;

    oled_boot_rom u_rom (
        .addr (q.ptr),
        .step (step)
    );

    oled_spi_tx #(.SCK_HALF(SCK_HALF)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (q.go),
        .byte_in ((q.st == SQ_VAL) ? step.val : step.idx),
        .dc_in   (q.st == SQ_VAL),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .cs_n    (spi_cs_n),
        .dc      (panel_dc),
        .idle    (tx_idle)
    );

    // frame finished: launched, the shifter has seen the launch and is back idle
    assign byte_done = q.sent && !q.go && tx_idle;

    always_comb begin
        d      = q;
        d.go   = 1'b0;
        d.done = 1'b0;
        case (q.st)
            SQ_IDLE: begin
                if (start) begin
                    d.st   = SQ_RST_HI;
                    d.cnt  = '0;
                    d.ptr  = '0;
                    d.sent = 1'b0;
                    d.prst = 1'b1;
                end
            end
            SQ_RST_HI: begin
                if (q.cnt == CW'(RST_CYC - 1)) begin
                    d.cnt  = '0;
                    d.prst = 1'b0;
                    d.st   = SQ_RST_LO;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            SQ_RST_LO: begin
                if (q.cnt == CW'(RST_CYC - 1)) begin
                    d.cnt = '0;
                    d.st  = SQ_IDX;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            SQ_IDX, SQ_VAL: begin
                if (!q.sent) begin
                    d.go   = 1'b1;
                    d.sent = 1'b1;
                end else if (byte_done) begin
                    d.sent = 1'b0;
                    if (q.st == SQ_IDX) begin
                        if (step.has_val) begin
                            d.st = SQ_VAL;
                        end else begin
                            d.st   = SQ_IDLE;
                            d.done = 1'b1;
                        end
                    end else if (step.pause) begin
                        d.st  = SQ_PAUSE;
                        d.cnt = '0;
                    end else begin
                        d.ptr = q.ptr + PTR_W'(1);
                        d.st  = SQ_IDX;
                    end
                end
            end
            SQ_PAUSE: begin
                if (q.cnt == CW'(WAIT_CYC - 1)) begin
                    d.cnt = '0;
                    d.ptr = q.ptr + PTR_W'(1);
                    d.st  = SQ_IDX;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: SQ_IDLE, ptr: '0, cnt: '0, sent: 1'b0, go: 1'b0, prst: 1'b0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign panel_rst = q.prst;
    assign busy      = (q.st != SQ_IDLE);
    assign done      = q.done;

    // R2
    quiet_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        panel_rst |-> spi_cs_n);
    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && spi_cs_n));
    // R8
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (q.ptr < PTR_W'(STEPS)));
endmodule

// File: tb/oled_boot_seq_tb.sv
module oled_boot_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 20000;
    localparam int WAIT_MS    = 5;
    localparam int SCK_HALF   = 2;
    localparam int RST_CYC    = 4;
    localparam int WAIT_CYC   = (CLK_HZ / 1000) * WAIT_MS;
    localparam int NFRAMES    = 47;
    localparam int CAP        = 128;

    // expected script: {index, value}; last entry is index only
    localparam logic [15:0] SCRIPT [24] = '{
        16'h0403, 16'h0400, 16'h3B00, 16'h0201, 16'h0390, 16'h8001,
        16'h0804, 16'h0905, 16'h0A05, 16'h0B9D, 16'h0C8C, 16'h0D57,
        16'h1056, 16'h114D, 16'h1246, 16'h1300, 16'h1401, 16'h1666,
        16'h287F, 16'h2900, 16'h0601, 16'h0500, 16'h1500, 16'h2200
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic spi_sck, spi_mosi, spi_cs_n, panel_dc, panel_rst, busy, done;

    int checks = 0;
    int errors = 0;

    oled_boot_seq #(
        .CLK_HZ(CLK_HZ), .WAIT_MS(WAIT_MS), .SCK_HALF(SCK_HALF), .RST_CYC(RST_CYC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
        .panel_dc(panel_dc), .panel_rst(panel_rst), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // cycle-level monitor
    longint cyc = 0;
    int     done_cnt = 0;
    int     done_wide = 0;
    logic   done_prev = 1'b0;
    logic   busy_prev = 1'b0;
    longint busy_fall [4];
    int     nbf = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (done) done_cnt <= done_cnt + 1;
        if (done && done_prev) done_wide <= done_wide + 1;
        done_prev <= done;
        busy_prev <= busy;
        if (busy_prev && !busy && nbf < 4) begin
            busy_fall[nbf] <= cyc;
            nbf <= nbf + 1;
        end
    end

    longint rst_rise [4];
    longint rst_fall [4];
    int     nrr = 0;
    int     nrf = 0;
    always @(posedge panel_rst) if (rst_n && nrr < 4) begin rst_rise[nrr] = cyc; nrr = nrr + 1; end
    always @(negedge panel_rst) if (rst_n && nrf < 4) begin rst_fall[nrf] = cyc; nrf = nrf + 1; end

    // SPI frame decoder
    logic [8:0] cap      [CAP];
    int         cap_bits [CAP];
    int         cap_dcer [CAP];
    int         cap_sckr [CAP];
    longint     cs_fall  [CAP];
    longint     cs_rise  [CAP];
    int         nfr = 0;
    logic       in_frame = 1'b0;
    logic [7:0] sh;
    int         nb;
    logic       dc_f;
    int         dcer;
    int         sckr;

    always @(negedge spi_cs_n) begin
        if (rst_n && nfr < CAP) begin
            in_frame = 1'b1;
            cs_fall[nfr] = cyc;
            sh = '0;
            nb = 0;
            dc_f = panel_dc;
            dcer = 0;
            sckr = spi_sck ? 1 : 0;
        end
    end
    always @(posedge spi_sck) begin
        if (in_frame) begin
            sh = {sh[6:0], spi_mosi};
            nb = nb + 1;
            if (panel_dc !== dc_f) dcer = dcer + 1;
        end
    end
    always @(posedge spi_cs_n) begin
        if (in_frame) begin
            if (spi_sck) sckr = sckr + 1;
            if (panel_dc !== dc_f) dcer = dcer + 1;
            cap[nfr]      = {dc_f, sh};
            cap_bits[nfr] = nb;
            cap_dcer[nfr] = dcer;
            cap_sckr[nfr] = sckr;
            cs_rise[nfr]  = cyc;
            nfr = nfr + 1;
            in_frame = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] expect_frame(input int k);
        int s = k / 2;
        if (k % 2 == 0) return {1'b0, SCRIPT[s][15:8]};
        return {1'b1, SCRIPT[s][7:0]};
    endfunction

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic check_run(input int base, input int run);
        for (int k = 0; k < NFRAMES; k++) begin
            // R5 R6 R8: content and order; R4: DC level per byte
            chk(cap[base+k] == expect_frame(k), "R5/R6/R8 frame byte", cap[base+k], expect_frame(k));
            // R3: eight rising edges, clock low at frame edges
            chk(cap_bits[base+k] == 8 && cap_sckr[base+k] == 0, "R3 frame shape",
                cap_bits[base+k], 8);
            // R4: DC stable through frame
            chk(cap_dcer[base+k] == 0, "R4 dc stable", cap_dcer[base+k], 0);
        end
        // R7: pause after the first two writes
        chk(cs_fall[base+2] - cs_rise[base+1] >= WAIT_CYC && cs_fall[base+2] - cs_rise[base+1] <= WAIT_CYC + 12,
            "R7 first pause", cs_fall[base+2] - cs_rise[base+1], WAIT_CYC);
        chk(cs_fall[base+4] - cs_rise[base+3] >= WAIT_CYC && cs_fall[base+4] - cs_rise[base+3] <= WAIT_CYC + 12,
            "R7 second pause", cs_fall[base+4] - cs_rise[base+3], WAIT_CYC);
        for (int k = 4; k < NFRAMES - 1; k++) begin
            if (k != 1 && k != 3)
                chk(cs_fall[base+k+1] - cs_rise[base+k] < 12, "R7 no other pause",
                    cs_fall[base+k+1] - cs_rise[base+k], 12);
        end
        chk(cs_fall[base] - cs_rise[base] == 0 || cs_rise[base] - cs_fall[base] >= 16 * SCK_HALF,
            "R3 frame length", cs_rise[base] - cs_fall[base], 16 * SCK_HALF);
        // R2: reset pulse widths and ordering
        chk(rst_fall[run] - rst_rise[run] == RST_CYC, "R2 reset high width",
            rst_fall[run] - rst_rise[run], RST_CYC);
        chk(cs_fall[base] - rst_fall[run] >= RST_CYC, "R2 reset before traffic",
            cs_fall[base] - rst_fall[run], RST_CYC);
        // R9: busy falls shortly after the last chip-select release
        chk(busy_fall[run] >= cs_rise[base+NFRAMES-1] && busy_fall[run] - cs_rise[base+NFRAMES-1] <= 2 * SCK_HALF + 3,
            "R9 busy end", busy_fall[run] - cs_rise[base+NFRAMES-1], SCK_HALF + 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=%0d expected=%0d", nfr, NFRAMES);
        $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state during reset
        chk(!busy && !done, "R1 flags in reset", {busy, done}, 0);
        chk(spi_cs_n && !spi_sck, "R1 spi idle in reset", {spi_cs_n, spi_sck}, 2);
        chk(!panel_rst, "R1 panel reset low", panel_rst, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(nfr == 0 && !busy && spi_cs_n, "R1 no traffic without start", nfr, 0);

        // first run, with a second start while busy (R10)
        pulse_start();
        chk(busy, "R9 busy after start", busy, 1);
        repeat (30) @(negedge clk);
        pulse_start();
        wait (done_cnt >= 1);
        repeat (50) @(negedge clk);
        chk(nfr == NFRAMES, "R10 frame count", nfr, NFRAMES);
        chk(done_cnt == 1 && done_wide == 0, "R10 R9 single done", done_cnt, 1);
        chk(!busy && spi_cs_n, "R9 idle after done", busy, 0);
        check_run(0, 0);

        // R11: replay after done
        pulse_start();
        wait (done_cnt >= 2);
        repeat (50) @(negedge clk);
        chk(nfr == 2 * NFRAMES, "R11 replay frame count", nfr, 2 * NFRAMES);
        chk(nrr == 2, "R11 replay reset pulse", nrr, 2);
        check_run(NFRAMES, 1);

        // R1: reset during a run returns to idle
        pulse_start();
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && spi_cs_n && !spi_sck && !panel_rst && !done, "R1 reset mid-run",
            {busy, spi_cs_n, spi_sck, panel_rst}, 4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule